// File: doc/BRIEF.md
# Loadable Modulo Counter and Clock Divider

This block is a synchronous binary counter with a width set by a parameter (4 bits by default). It has an asynchronous active-low clear, a synchronous active-low parallel load and a count enable. A terminal carry output is high whenever every counter bit is one. In free-running use, each counter bit is a clock divided by a power of two.

A wrap mode turns the counter into a programmable modulo-n counter. When the counter value equals a chosen end value and counting is enabled, the next rising edge synchronously reloads a chosen start value. The count therefore runs from the start value to the end value and repeats. The same condition drives a reload pulse output that is high for one cycle in every n cycles, so the pulse can serve as a divide-by-n clock enable. The reload is registered through the synchronous load path, so no short-lived counter state ever appears.

When several controls are active at once, the priority is: clear, then external load, then wrap reload, then count, then hold.

Top module: `modcnt_top`

## Requirements
- R1: A low `clr_n` forces `q` to 0 at once, without waiting for a clock edge. While `clr_n` stays low, `q` remains 0 at every clock edge, whatever the other inputs are.
- R2: With `clr_n` high and `ld_n` low, the value on `ld_val` is stored into `q` at the rising edge.
- R3: With `clr_n` and `ld_n` high, `cnt_en` high and no reload due, `q` advances by one at each rising edge.
- R4: With `clr_n` and `ld_n` high and `cnt_en` low, `q` keeps its value and `reload_pulse` is low, even when `q` equals `end_val`.
- R5: `carry` is high exactly while `q` holds the all-ones value (15 at the default width).
- R6: When counting with `wrap_en` low, `q` rolls over from all ones to 0.
- R7: With `wrap_en` high, `cnt_en` high and `ld_n` high, a `q` equal to `end_val` is replaced by `start_val` at the next edge. For example, start 3 and end 7 give the repeating sequence 3,4,5,6,7, and start 11 and end 15 give 11 to 15.
- R8: `reload_pulse` is high exactly in the cycles where `wrap_en` is high, `cnt_en` is high and `q` equals `end_val`. In steady modulo-n counting, it goes high once per n cycles, at a fixed spacing of n cycles.
- R9: Cycle length is ((end_val - start_val) mod 2^W) + 1. An end value below the start value counts through the rollover (start 14 and end 1 give 14,15,0,1). Equal start and end values hold `q` there with `reload_pulse` high in every cycle.
- R10: An external load (`ld_n` low) takes priority over a wrap reload that is due in the same cycle.
- R11: In free-running counting from 0, bit k of `q` changes value once every 2^k cycles, which divides the clock by 2^(k+1).
- R12: With `wrap_en` low, `end_val` and `start_val` have no effect, and `reload_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable |
| wrap_en | input | 1 | Enables modulo mode (end detection and reload) |
| ld_val | input | W | Data stored on an external load |
| start_val | input | W | Value reloaded after the end value |
| end_val | input | W | Last value of the modulo sequence |
| q | output | W | Counter value; bit 0 is the least significant bit |
| carry | output | 1 | High while `q` is all ones |
| reload_pulse | output | 1 | One-cycle pulse in the cycle before a wrap reload |

## Verification
The bench first counts freely across the rollover, which separates the carry and rollover behaviour from the load and hold paths. It then runs two modulo windows taken from the block's use: 3 to 7, and 11 to 15, where the end value coincides with the carry. A window whose end value is below its start value exposes any comparison that assumes end is greater than start. A one-value window exposes any pulse logic that assumes n is at least 2. The bench also applies a collision of external load with a pending wrap reload, a pending reload with counting paused, and a clear applied in mid-cycle. Together these confirm the priority order, and that the clear acts without a clock edge.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

  // Next-state selection for the counter register, in rising priority.
  typedef enum logic [1:0] {
    NXT_HOLD  = 2'd0,
    NXT_COUNT = 2'd1,
    NXT_WRAP  = 2'd2,
    NXT_LOAD  = 2'd3
  } nxt_e;

endpackage

// File: rtl/modcnt_core.sv
module modcnt_core
  import modcnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  nxt_e         op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q_r <= '0;
    end else begin
      case (op)
        NXT_LOAD, NXT_WRAP: q_r <= din;
        NXT_COUNT:          q_r <= incr(q_r);
        default:            q_r <= q_r;
      endcase
    end
  end

  // Terminal detect built as a ripple AND chain across the bits.
  logic [W:0] all_ones;
  assign all_ones[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_tc
    assign all_ones[i+1] = all_ones[i] & q_r[i];
  end

  assign q     = q_r;
  assign carry = all_ones[W];

endmodule

// File: rtl/modcnt_match.sv
module modcnt_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic [W-1:0] end_val,
  input  logic         wrap_en,
  input  logic         cnt_en,
  output logic         hit
);

  // Per-bit equality, reduced afterwards.
  logic [W-1:0] bit_eq;
  for (genvar i = 0; i < W; i++) begin : g_eq
    assign bit_eq[i] = ~(q[i] ^ end_val[i]);
  end

  assign hit = wrap_en & cnt_en & (&bit_eq);

endmodule

// File: rtl/modcnt_sel.sv
module modcnt_sel
  import modcnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         ld_n,
  input  logic         cnt_en,
  input  logic         hit,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] start_val,
  output nxt_e         op,
  output logic [W-1:0] din
);

  always_comb begin
    op  = NXT_HOLD;
    din = start_val;
    if (!ld_n) begin
      op  = NXT_LOAD;
      din = ld_val;
    end else if (hit) begin
      op  = NXT_WRAP;
    end else if (cnt_en) begin
      op  = NXT_COUNT;
    end
  end

endmodule

// File: rtl/modcnt_top.sv
module modcnt_top
  import modcnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         cnt_en,
  input  logic         wrap_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] end_val,
  output logic [W-1:0] q,
  output logic         carry,
  output logic         reload_pulse
);

  // Internal events brought out as named wires.
  logic         end_hit;
  nxt_e         nxt_op;
  logic [W-1:0] nxt_din;
  logic [W-1:0] q_int;
  logic         carry_int;

  modcnt_match #(.W(W)) u_match (
    .q       (q_int),
    .end_val (end_val),
    .wrap_en (wrap_en),
    .cnt_en  (cnt_en),
    .hit     (end_hit)
  );

  modcnt_sel #(.W(W)) u_sel (
    .ld_n      (ld_n),
    .cnt_en    (cnt_en),
    .hit       (end_hit),
    .ld_val    (ld_val),
    .start_val (start_val),
    .op        (nxt_op),
    .din       (nxt_din)
  );

  modcnt_core #(.W(W)) u_core (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (nxt_op),
    .din   (nxt_din),
    .q     (q_int),
    .carry (carry_int)
  );

  assign q            = q_int;
  assign carry        = carry_int;
  assign reload_pulse = end_hit;

endmodule

// File: rtl/modcnt_checker.sv
module modcnt_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic         ld_n,
  input logic         cnt_en,
  input logic         wrap_en,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] start_val,
  input logic [W-1:0] q,
  input logic         carry,
  input logic         reload_pulse
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(ld_val));

  assert_count_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && !reload_pulse) |=> q == W'($past(q) + 1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !cnt_en) |=> $stable(q));

  assert_rollover_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && !wrap_en && carry) |=> q == '0);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && reload_pulse) |=> q == $past(start_val));

endmodule

bind modcnt_top modcnt_checker #(.W(W)) u_chk (
  .clk          (clk),
  .clr_n        (clr_n),
  .ld_n         (ld_n),
  .cnt_en       (cnt_en),
  .wrap_en      (wrap_en),
  .ld_val       (ld_val),
  .start_val    (start_val),
  .q            (q),
  .carry        (carry),
  .reload_pulse (reload_pulse)
);

// File: tb/modcnt_top_test.sv
`timescale 1ns/100ps
module modcnt_top_test;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic clr_n, ld_n, cnt_en, wrap_en;
  logic [W-1:0] ld_val, start_val, end_val;
  logic [W-1:0] q;
  logic carry, reload_pulse;

  int checks = 0;
  int failures = 0;
  int m = 0;          // reference counter value
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modcnt_top #(.W(W)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en), .wrap_en(wrap_en),
    .ld_val(ld_val), .start_val(start_val), .end_val(end_val),
    .q(q), .carry(carry), .reload_pulse(reload_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_pulse();
    return (wrap_en && cnt_en && m == int'(end_val)) ? 1 : 0;
  endfunction

  task automatic compare(input string tag);
    chk(int'(q) == m, tag, int'(q), m);
    chk(int'(carry) == ((m == M - 1) ? 1 : 0), {tag, "/R5"}, int'(carry), (m == M - 1) ? 1 : 0);
    chk(int'(reload_pulse) == exp_pulse(), {tag, "/R8"}, int'(reload_pulse), exp_pulse());
  endtask

  // One clock: behavioural reference update at the edge, compare at the falling edge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (!clr_n)                                        m = 0;
    else if (!ld_n)                                    m = int'(ld_val);
    else if (cnt_en && wrap_en && m == int'(end_val))  m = int'(start_val);
    else if (cnt_en)                                   m = (m + 1) % M;
    cyc++;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int last_pulse;
    int npulse;
    int tog [W];
    logic [W-1:0] prev;

    clr_n = 0; ld_n = 1; cnt_en = 0; wrap_en = 0;
    ld_val = '0; start_val = '0; end_val = '0;
    #7;
    compare("R1 reset");
    @(negedge clk);
    clr_n = 1;

    // R2: parallel load
    ld_n = 0; ld_val = 4'd9;
    tick("R2 load 9");
    ld_n = 1; cnt_en = 1;
    // R3, R5, R6: count through carry and rollover
    for (int i = 0; i < 9; i++) tick("R3/R6 count");
    chk(int'(q) == 2, "R6 rollover", int'(q), 2);

    // R4: hold
    cnt_en = 0;
    for (int i = 0; i < 3; i++) tick("R4 hold");

    // R1: clear in mid-cycle, no edge needed
    #1 clr_n = 0;
    #0.5;
    chk(q == '0, "R1 async clear", int'(q), 0);
    m = 0;
    ld_n = 0; ld_val = 4'd5; cnt_en = 1;
    tick("R1 clear overrides load");
    tick("R1 clear overrides load");
    clr_n = 1; ld_n = 1;

    // R12: end value ignored without wrap mode
    end_val = 4'd1; start_val = 4'd8;
    for (int i = 0; i < 4; i++) tick("R12 no wrap");
    chk(reload_pulse == 1'b0, "R12 no pulse", int'(reload_pulse), 0);

    // R7/R8: modulo 5 from 3 to 7
    wrap_en = 1; start_val = 4'd3; end_val = 4'd7;
    ld_n = 0; ld_val = 4'd3;
    tick("R7 preload 3");
    ld_n = 1;
    last_pulse = -1; npulse = 0;
    for (int i = 0; i < 20; i++) begin
      tick("R7 mod5 3..7");
      if (reload_pulse) begin
        npulse++;
        if (last_pulse >= 0) chk(cyc - last_pulse == 5, "R8 pulse spacing", cyc - last_pulse, 5);
        last_pulse = cyc;
      end
    end
    chk(npulse == 4, "R8 pulses per 20 cycles", npulse, 4);

    // R7: 11 to 15 using the carry value as end
    start_val = 4'd11; end_val = 4'd15;
    ld_n = 0; ld_val = 4'd11;
    tick("R7 preload 11");
    ld_n = 1;
    for (int i = 0; i < 12; i++) tick("R7 mod5 11..15");

    // R9: end below start, wraps through zero
    start_val = 4'd14; end_val = 4'd1;
    ld_n = 0; ld_val = 4'd14;
    tick("R9 preload 14");
    ld_n = 1;
    for (int i = 0; i < 9; i++) tick("R9 14,15,0,1");

    // R9: single-value window
    start_val = 4'd6; end_val = 4'd6;
    ld_n = 0; ld_val = 4'd6;
    tick("R9 preload 6");
    ld_n = 1;
    for (int i = 0; i < 4; i++) tick("R9 n=1");
    chk(reload_pulse == 1'b1, "R9 steady pulse", int'(reload_pulse), 1);

    // R4: pending reload paused by enable low
    cnt_en = 0;
    for (int i = 0; i < 2; i++) tick("R4 paused at end");

    // R10: external load beats pending reload
    cnt_en = 1; ld_n = 0; ld_val = 4'd2;
    tick("R10 load over reload");
    chk(int'(q) == 2, "R10 load value", int'(q), 2);
    ld_n = 1;

    // R11: free-running divide
    wrap_en = 0;
    ld_n = 0; ld_val = 4'd0;
    tick("R11 preload 0");
    ld_n = 1;
    for (int k = 0; k < W; k++) tog[k] = 0;
    prev = q;
    for (int i = 0; i < 32; i++) begin
      tick("R11 free run");
      for (int k = 0; k < W; k++) if (q[k] != prev[k]) tog[k]++;
      prev = q;
    end
    for (int k = 0; k < W; k++) chk(tog[k] == (32 >> k), "R11 bit toggles", tog[k], 32 >> k);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule